// File: doc/BRIEF.md
# Paged SPI EEPROM Store Sequencer

This block moves a run of bytes from a small local buffer into a serial EEPROM over SPI. The host pulses `start` with a 16-bit target address and a byte count. The block then reads the buffer from index 0 upward and cuts the run into pieces that never cross a 64-byte page. Each piece gets its own three-step exchange with the memory:
- a one-byte enable frame,
- a write frame that carries the address and the data,
- status reads that repeat until the memory reports that its internal programming has finished.

The serial clock is derived from the system clock by a parameterised divider and follows SPI mode 0. Chip select is released between frames for a parameterised minimum number of cycles. A bounded poll counter stops a transfer whose memory never reports ready, and reports it on `error`. A request with a count of zero finishes at once.

Top module: `eeprom_wr_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `error` are 0.
- R2: Before every write frame, the block sends a frame of its own that holds only the byte 0x06.
- R3: A write frame is the byte 0x02, then the address high byte, then the address low byte, then the data bytes. The data bytes are taken from `buf_byte` at `buf_idx` = 0, 1, 2, … in order.
- R4: A write frame carries at most 64 data bytes and ends at the next address whose low six bits are zero. The following piece starts at that address.
- R5: After each write frame, the block sends status frames of two bytes, 0x05 then 0x00. It sends no other frame while bit 0 of the second byte returned on `spi_miso` reads 1.
- R6: `spi_sck` is low whenever `spi_cs_n` is high. Each high phase lasts `SCK_DIV` system cycles. `spi_mosi` holds steady while `spi_sck` is high. The returned bits are sampled on the rising edge, most significant bit first.
- R7: Between two frames, `spi_cs_n` stays high for at least `CS_GAP` cycles.
- R8: If `MAX_POLLS` consecutive status frames all return bit 0 = 1, then `error` pulses for one cycle and the transfer ends. No `done` pulse follows.
- R9: A start with `length` = 0 while idle raises `done` on the next cycle, with no chip-select activity and without `busy` being raised.
- R10: `busy` is 1 from the cycle after an accepted start until the end of the transfer. `done` is a one-cycle pulse that follows the status frame reporting bit 0 = 0 for the last piece.
- R11: A `start` pulse while `busy` is 1 is ignored, and the transfer in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | 16 | First EEPROM address |
| length | input | LEN_W | Number of bytes to store |
| buf_idx | output | LEN_W | Index into the local byte buffer |
| buf_byte | input | 8 | Buffer byte at `buf_idx` (combinational read) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle poll-timeout pulse |

## Verification
Two results have a fixed cycle: `busy` and the zero-length `done`. Both come one register after the edge that samples `start`, so the bench drives `start` on a falling edge and reads them on the next falling edge. The SPI frames have no fixed cycle. The bench therefore compares them whole when chip select rises: a memory model collects each frame and checks it against a queue of frames that the driver computed in advance from the address, the length and the busy count. The end of a transfer is awaited by sampling `done`/`error` on every falling edge. The cycle after that end is then checked to confirm a single-cycle pulse. Clock phase widths and chip-select gaps are measured cycle by cycle on falling edges.

// File: rtl/ewq_pkg.sv
package ewq_pkg;

    localparam logic [7:0] CMD_ENABLE = 8'h06;
    localparam logic [7:0] CMD_STORE  = 8'h02;
    localparam logic [7:0] CMD_STATUS = 8'h05;
    localparam logic [7:0] FILL_BYTE  = 8'h00;
    localparam int         HDR_BYTES  = 3;

    typedef enum logic [1:0] {
        FR_ENABLE,
        FR_STORE,
        FR_STATUS
    } frame_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_LOAD,
        ST_SHIFT
    } seq_state_e;

    // Header byte of a frame, chosen by kind and byte position.
    function automatic logic [7:0] header_byte(frame_kind_e kind, int unsigned pos,
                                               logic [15:0] addr);
        logic [7:0] b;
        case (kind)
            FR_ENABLE: b = CMD_ENABLE;
            FR_STATUS: b = (pos == 0) ? CMD_STATUS : FILL_BYTE;
            default: begin
                if (pos == 0)      b = CMD_STORE;
                else if (pos == 1) b = addr[15:8];
                else               b = addr[7:0];
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ewq_shifter.sv
module ewq_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       fin
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    logic          active;
    logic          phase_hi;
    logic [2:0]    bit_n;
    logic [CW-1:0] cnt;
    logic [7:0]    sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase_hi <= 1'b0;
            bit_n    <= '0;
            cnt      <= '0;
            sreg     <= '0;
            sck      <= 1'b0;
            rx       <= '0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active   <= 1'b1;
                sreg     <= tx;
                cnt      <= '0;
                phase_hi <= 1'b0;
                bit_n    <= '0;
                sck      <= 1'b0;
            end else if (active) begin
                if (cnt == CNT_LAST) begin
                    cnt <= '0;
                    if (!phase_hi) begin
                        // rising edge: capture the returned bit
                        sck      <= 1'b1;
                        phase_hi <= 1'b1;
                        rx       <= {rx[6:0], miso};
                    end else begin
                        // falling edge: present the next bit
                        sck      <= 1'b0;
                        phase_hi <= 1'b0;
                        if (bit_n == 3'd7) begin
                            active <= 1'b0;
                            fin    <= 1'b1;
                        end else begin
                            bit_n <= bit_n + 3'd1;
                            sreg  <= {sreg[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign mosi = sreg[7];

endmodule

// File: rtl/ewq_chunker.sv
module ewq_chunker #(
    parameter int LEN_W  = 16,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [15:0]       addr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              take,
    input  logic              advance,
    output logic [15:0]       cur_addr,
    output logic [PAGE_W:0]   piece_len,
    output logic              all_stored,
    output logic [LEN_W-1:0]  buf_idx
);
    localparam logic [PAGE_W:0] PAGE_SIZE = (PAGE_W+1)'(1 << PAGE_W);

    logic [LEN_W-1:0] remain;
    logic [PAGE_W:0]  room;

    assign room       = PAGE_SIZE - {1'b0, cur_addr[PAGE_W-1:0]};
    assign piece_len  = (remain < LEN_W'(room)) ? remain[PAGE_W:0] : room;
    assign all_stored = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
            buf_idx  <= '0;
        end else if (load) begin
            cur_addr <= addr_in;
            remain   <= len_in;
            buf_idx  <= '0;
        end else begin
            if (take)
                buf_idx <= buf_idx + LEN_W'(1);
            if (advance) begin
                cur_addr <= cur_addr + 16'(piece_len);
                remain   <= remain - LEN_W'(piece_len);
            end
        end
    end

endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
    import ewq_pkg::*;
#(
    parameter int SCK_DIV    = 2,
    parameter int CS_GAP     = 4,
    parameter int MAX_POLLS  = 1000,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      start_addr,
    input  logic [LEN_W-1:0] length,
    output logic [LEN_W-1:0] buf_idx,
    input  logic [7:0]       buf_byte,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             busy,
    output logic             done,
    output logic             error
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int KW     = PAGE_W + 2;
    localparam int GW     = $clog2(CS_GAP + 1);
    localparam int PW     = $clog2(MAX_POLLS + 1);

    seq_state_e       state;
    frame_kind_e      kind;
    logic [KW-1:0]    pos;
    logic [KW-1:0]    last_pos;
    logic [GW-1:0]    gap_cnt;
    logic [PW-1:0]    poll_cnt;

    logic             go;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             fin;
    logic             load;
    logic             take;
    logic             advance;
    logic [15:0]      cur_addr;
    logic [PAGE_W:0]  piece_len;
    logic             all_stored;
    logic             frame_end;

    assign busy      = (state != ST_IDLE);
    assign load      = (state == ST_IDLE) && start && (length != '0);
    assign go        = (state == ST_LOAD);
    assign frame_end = (state == ST_SHIFT) && fin && (pos == last_pos);
    assign take      = go && (kind == FR_STORE) && (pos >= KW'(HDR_BYTES));
    assign advance   = frame_end && (kind == FR_STORE);

    always_comb begin
        case (kind)
            FR_ENABLE: last_pos = '0;
            FR_STATUS: last_pos = KW'(1);
            default:   last_pos = KW'(piece_len) + KW'(HDR_BYTES - 1);
        endcase
    end

    always_comb begin
        if (kind == FR_STORE && pos >= KW'(HDR_BYTES))
            tx_byte = buf_byte;
        else
            tx_byte = header_byte(kind, int'(pos), cur_addr);
    end

    ewq_shifter #(.DIV(SCK_DIV)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .tx   (tx_byte),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .rx   (rx_byte),
        .fin  (fin)
    );

    ewq_chunker #(.LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_chunk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .addr_in    (start_addr),
        .len_in     (length),
        .take       (take),
        .advance    (advance),
        .cur_addr   (cur_addr),
        .piece_len  (piece_len),
        .all_stored (all_stored),
        .buf_idx    (buf_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= FR_ENABLE;
            pos      <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && length == '0) begin
                        done <= 1'b1;
                    end else if (start) begin
                        kind    <= FR_ENABLE;
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(CS_GAP - 1)) begin
                        spi_cs_n <= 1'b0;
                        pos      <= '0;
                        state    <= ST_LOAD;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                ST_LOAD: begin
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (fin && pos != last_pos) begin
                        pos   <= pos + KW'(1);
                        state <= ST_LOAD;
                    end else if (frame_end) begin
                        spi_cs_n <= 1'b1;
                        gap_cnt  <= '0;
                        state    <= ST_GAP;
                        case (kind)
                            FR_ENABLE: kind <= FR_STORE;
                            FR_STORE: begin
                                kind     <= FR_STATUS;
                                poll_cnt <= '0;
                            end
                            default: begin
                                if (rx_byte[0]) begin
                                    if (poll_cnt == PW'(MAX_POLLS - 1)) begin
                                        error <= 1'b1;
                                        state <= ST_IDLE;
                                    end else begin
                                        poll_cnt <= poll_cnt + PW'(1);
                                    end
                                end else if (all_stored) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    kind <= FR_ENABLE;
                                end
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ewq_checker.sv
module ewq_checker #(
    parameter int CS_GAP = 4,
    parameter int LEN_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] length,
    input logic             busy,
    input logic             cs_n,
    input logic             sck,
    input logic             mosi,
    input logic             done,
    input logic             error
);
    int unsigned high_run;

    always_ff @(posedge clk) begin
        if (rst)
            high_run <= CS_GAP;
        else if (cs_n)
            high_run <= (high_run >= CS_GAP) ? high_run : high_run + 1;
        else
            high_run <= 0;
    end

    p_sck_idle_r6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (high_run >= CS_GAP));

    p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && length == '0) |=> (done && !busy));

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && length != '0) |=> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    p_idle_after_err_r8: assert property (@(posedge clk) disable iff (rst)
        error |-> (cs_n && !busy));

endmodule

bind eeprom_wr_seq ewq_checker #(.CS_GAP(CS_GAP), .LEN_W(LEN_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .length (length),
    .busy   (busy),
    .cs_n   (spi_cs_n),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .done   (done),
    .error  (error)
);

// File: tb/sim_eeprom_wr_seq.sv
`timescale 1ns/1ps
module sim_eeprom_wr_seq;
    localparam int DIV   = 2;
    localparam int GAP   = 3;
    localparam int MAXP  = 6;
    localparam int LW    = 16;

    typedef struct packed {
        logic [7:0]      n;
        logic [8*70-1:0] b;
    } frame_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   start_addr = '0;
    logic [LW-1:0] length = '0;
    logic [LW-1:0] buf_idx;
    logic [7:0]    buf_byte;
    logic          cs_n, sck, mosi, miso, busy, done, error;

    int nchk = 0, nfail = 0;
    logic [7:0] bufm [0:1023];
    logic [7:0] mem  [0:4095];
    logic [7:0] emem [0:4095];
    frame_t exp_q[$];

    // memory model state
    int     bitcnt = 0;
    logic [7:0] sh = '0;
    frame_t obs = '0;
    logic   wel = 1'b0, wip = 1'b0;
    int     busy_left = 0, busy_n = 0;
    int     viol_proto = 0, viol_sck = 0, viol_hi = 0, viol_gap = 0;
    int     hicnt = 0, gapc = 0;

    always #10 clk = ~clk;

    assign buf_byte = bufm[buf_idx[9:0]];
    assign miso = (!cs_n && bitcnt >= 8 && bitcnt < 16) ? ({7'b0, wip} >> (15 - bitcnt)) != 0 : 1'b0;

    eeprom_wr_seq #(.SCK_DIV(DIV), .CS_GAP(GAP), .MAX_POLLS(MAXP), .LEN_W(LW),
                    .PAGE_BYTES(64)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
        .buf_idx(buf_idx), .buf_byte(buf_byte), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .busy(busy), .done(done), .error(error));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: collect frames, compare with scoreboard at chip-select release
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            if (bitcnt > 0) begin
                frame_t e;
                int nb;
                int bad;
                nb = bitcnt / 8;
                chk(bitcnt % 8 == 0, "R6", "whole bytes per frame", bitcnt, nb * 8);
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected frame opcode", obs.b[7:0], 0);
                end else begin
                    e = exp_q.pop_front();
                    bad = -1;
                    for (int i = 0; i < nb && i < 70; i++)
                        if (bad < 0 && obs.b[8*i +: 8] !== e.b[8*i +: 8]) bad = i;
                    chk(nb == int'(e.n), "R4", "frame length", nb, e.n);
                    if (bad >= 0)
                        chk(0, "R3", $sformatf("frame byte %0d", bad),
                            obs.b[8*bad +: 8], e.b[8*bad +: 8]);
                    else
                        chk(1, "R2", "frame bytes", 0, 0);
                end
                // model effect
                if (obs.b[7:0] == 8'h06 && nb == 1) begin
                    if (!wip) wel = 1'b1;
                end else if (obs.b[7:0] == 8'h02 && nb >= 3) begin
                    if (!wel || wip) viol_proto++;
                    for (int i = 3; i < nb; i++) begin
                        logic [15:0] a;
                        a = {obs.b[15:8], obs.b[23:16]};
                        a = (a & 16'hFFC0) | ((a + 16'(i - 3)) & 16'h003F);
                        mem[a[11:0]] = obs.b[8*i +: 8];
                    end
                    wel = 1'b0;
                    busy_left = busy_n;
                    wip = (busy_n > 0);
                end else if (obs.b[7:0] == 8'h05) begin
                    if (busy_left > 0) busy_left--;
                    if (busy_left == 0) wip = 1'b0;
                end
            end
            bitcnt = 0;
            obs = '0;
        end else begin
            sh = {sh[6:0], mosi};
            bitcnt++;
            if (bitcnt % 8 == 0 && bitcnt / 8 <= 70)
                obs.b[8*(bitcnt/8 - 1) +: 8] = sh;
        end
    end

    // cycle monitors for clock shape and chip-select gaps
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n && sck) viol_sck++;
            if (sck) hicnt++;
            else if (hicnt != 0) begin
                if (hicnt != DIV) viol_hi++;
                hicnt = 0;
            end
            if (cs_n) gapc++;
            else begin
                if (gapc > 0 && gapc < GAP) viol_gap++;
                gapc = 0;
            end
        end
    end

    function automatic frame_t mk1(input logic [7:0] b0);
        frame_t f = '0;
        f.n = 8'd1; f.b[7:0] = b0;
        return f;
    endfunction

    task automatic push_polls(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            frame_t f = '0;
            f.n = 8'd2; f.b[7:0] = 8'h05; f.b[15:8] = 8'h00;
            exp_q.push_back(f);
        end
    endtask

    // driver: compute expected frames, then issue the request
    task automatic run_xfer(input logic [15:0] addr, input int len, input int bn,
                            input bit expect_err, input bit poke_start);
        int a = addr, r = len, idx = 0;
        int got_done = 0, got_err = 0, cyc = 0;
        busy_n = bn;
        wip = 1'b0; wel = 1'b0; busy_left = 0;
        while (r > 0) begin
            int c;
            frame_t f = '0;
            c = 64 - (a % 64);
            if (r < c) c = r;
            exp_q.push_back(mk1(8'h06));
            f.n = 8'(3 + c);
            f.b[7:0] = 8'h02; f.b[15:8] = 8'(a >> 8); f.b[23:16] = 8'(a);
            for (int i = 0; i < c; i++) begin
                f.b[8*(3+i) +: 8] = bufm[idx + i];
                emem[(a + i) % 4096] = bufm[idx + i];
            end
            exp_q.push_back(f);
            if (expect_err) begin
                push_polls(MAXP);
                break;
            end
            push_polls(bn + 1);
            a += c; r -= c; idx += c;
        end
        @(negedge clk);
        start = 1'b1; start_addr = addr; length = LW'(len);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accepted start", busy, 1);
        for (cyc = 0; cyc < 60000; cyc++) begin
            if (poke_start && cyc == 40) begin
                start = 1'b1; start_addr = 16'h0FF0; length = '0;
            end
            if (poke_start && cyc == 41) start = 1'b0;
            @(negedge clk);
            if (done) got_done++;
            if (error) got_err++;
            if (done || error) break;
        end
        if (expect_err) begin
            chk(got_err == 1, "R8", "error pulse on poll timeout", got_err, 1);
            chk(got_done == 0, "R8", "no done after timeout", got_done, 0);
        end else begin
            chk(got_done == 1, "R10", "done at end", got_done, 1);
            chk(got_err == 0, "R10", "no error", got_err, 0);
        end
        chk(exp_q.size() == 0, poke_start ? "R11" : "R5", "frames pending at end",
            exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        chk(!done && !error && !busy && cs_n, "R10", "single-cycle end, idle after",
            {done, error, busy, cs_n}, 4'b0001);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) bufm[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 4096; i++) begin mem[i] = 8'hFF; emem[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sck === 1'b0, "R1", "bus idle in reset", {cs_n, sck}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !error, "R1", "flags low after reset", {busy, done, error}, 0);

        // R9: zero length completes on the next cycle with no bus activity
        start = 1'b1; start_addr = 16'h0123; length = '0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R9", "zero-length done", {done, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0 && cs_n == 1'b1, "R9", "zero-length no frame", {done, cs_n}, 2'b01);

        run_xfer(16'h0040, 64, 2, 1'b0, 1'b0);   // R2 R3 R5 aligned full page
        run_xfer(16'h0075, 100, 1, 1'b0, 1'b0);  // R4 split 11/64/25
        run_xfer(16'h0203, 5, 0, 1'b0, 1'b0);    // R3 short piece, no busy
        run_xfer(16'h0300, 70, 3, 1'b0, 1'b1);   // R11 start ignored while busy
        run_xfer(16'h0500, 10, 1000, 1'b1, 1'b0);// R8 timeout
        run_xfer(16'h07F8, 16, 1, 1'b0, 1'b0);   // R4 cross after error recovery

        begin
            int bad = 0;
            for (int i = 0; i < 4096; i++) if (mem[i] !== emem[i]) bad++;
            chk(bad == 0, "R3", "stored memory image mismatches", bad, 0);
        end
        chk(viol_proto == 0, "R2", "write without enable or while busy", viol_proto, 0);
        chk(viol_sck == 0, "R6", "sck high with cs_n high", viol_sck, 0);
        chk(viol_hi == 0, "R6", "sck high phase width", viol_hi, 0);
        chk(viol_gap == 0, "R7", "short chip-select gaps", viol_gap, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog R10: cycles %0d expected completion before", 190000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule